// File: doc/BRIEF.md
# Hotplug slot command engine

This block executes the one-byte commands that software writes into a hotplug controller's command register. It holds per-slot records for a configurable number of slots (1 to 31). Each record has a slot state, a power indicator, an attention indicator, a latch-open bit and a presence code.

Commands fall into three groups:
- Slot commands act on one slot, named by a 5-bit logical target.
- Bus-speed commands only ever accept the 33 MHz setting.
- Group commands power or enable every slot whose latch is closed.

Commands that would make an illegal state move are refused, and this is reported in a small command status word. When a slot is disabled while its power indicator is off, the slot is treated as emptied.

Single-slot, speed and invalid commands complete in the clock edge that accepts them. Group commands first check all slots in that same edge. They then visit one slot per clock while the busy bit is high. A command-detected pulse marks the end of every command.

The latch-open and presence sense inputs drive the stored per-slot fields. A stored field takes the sense value on the clock after that input changes.

Top module: `hotplug_cmd_engine`

## Requirements
- R1: While reset is asserted, every slot shows state 3 (disabled), power indicator 3 (off), attention indicator 0, latch-open 1 and presence 3. In the same state, cmd_status and cmd_detected are 0 and no event pulse is high.
- R2: A code in 0x00..0x3F is a slot command. Its fields are:
  - bits [1:0]: requested state (0 no change, 1 power-only, 2 enabled, 3 disabled);
  - bits [3:2]: power indicator;
  - bits [5:4]: attention indicator (0 no change, 1 on, 2 blink, 3 off).
  A nonzero indicator field is written to the slot. A state move happens only in three cases: disabled to power-only, disabled to enabled, and power-only or enabled to disabled. Any other request leaves the state as it is.
- R3: For a slot command, a target of 0 or a target above NSLOTS sets cmd_status bit 2 (invalid command) and changes no slot field.
- R4: A slot command that asks an enabled slot for power-only sets cmd_status bit 2. It leaves every field of that slot unchanged, including the indicators.
- R5: A slot command that moves a slot into disabled empties the slot if the power indicator (after its own write) is 3. Emptying sets latch-open to 1 and presence to 3. It also pulses evt_button, evt_latch and evt_presence for that slot for one cycle.
- R6: Codes 0x40..0x47 are bus-speed commands. Code 0x40 is accepted with no error bit. Codes 0x41..0x47 set cmd_status bit 3 (invalid mode).
- R7: Code 0x48 requests power-only for all slots and code 0x49 requests enable for all slots. If any slot is enabled when the code is accepted, cmd_status bit 2 is set and no slot changes. Otherwise each latch-closed slot gets the requested state with power indicator 1. Each latch-open slot gets no state change and power indicator 3.
- R8: Every code from 0x4A to 0xFF sets cmd_status bit 2. Accepting any command first clears cmd_status bits 1 to 3. Bit 1 (latch-open error) is never set.
- R9: cmd_detected pulses for one cycle after every command, valid or not. For a non-group command it is high in the cycle after the accepting edge. For an accepted group command it is high in the cycle after the last slot is visited, and it is low while busy.
- R10: cmd_status bit 0 (busy) is high for exactly NSLOTS cycles during a group command. A command written while busy is ignored: it sets no status bit and changes no slot.
- R11: A change on a slot's latch-open or presence sense input is copied into the stored field on the next clock. If the same slot is emptied on that clock, the emptied values take priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code byte |
| cmd_target | input | 5 | Logical target slot (1..NSLOTS) |
| sense_latch_open | input | NSLOTS | Per-slot latch-open sense |
| sense_presence | input | 2*NSLOTS | Per-slot presence sense, 2 bits per slot |
| slot_state | output | 2*NSLOTS | Per-slot state |
| slot_pwr_led | output | 2*NSLOTS | Per-slot power indicator |
| slot_attn_led | output | 2*NSLOTS | Per-slot attention indicator |
| slot_latch_open | output | NSLOTS | Per-slot stored latch-open bit |
| slot_presence | output | 2*NSLOTS | Per-slot stored presence code |
| cmd_status | output | 4 | {invalid mode, invalid command, latch-open error, busy} |
| cmd_detected | output | 1 | One-cycle end-of-command pulse |
| evt_button | output | NSLOTS | Button event pulse on emptying |
| evt_latch | output | NSLOTS | Latch event pulse on emptying |
| evt_presence | output | NSLOTS | Presence event pulse on emptying |

## Verification
The case that needs care is a slot being emptied by a disable command on the same clock that its presence sense input changes. Both actions want to write the stored presence field. The bench enables a slot, then issues the disabling, power-off code on the same edge where it moves the presence sense input to a third value. The stored presence must read the empty code 3, not the sense value. A later sense change must still be picked up. The other pair that meets in one cycle is a new command write arriving while a group command is stepping through the slots. The bench writes an invalid code during busy and checks that the status shows no error when the group command completes.

// File: rtl/hotplug_cmd_engine.sv
module hotplug_cmd_engine #(
  parameter int NSLOTS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_wr,
  input  logic [7:0]            cmd_code,
  input  logic [4:0]            cmd_target,
  input  logic [NSLOTS-1:0]     sense_latch_open,
  input  logic [2*NSLOTS-1:0]   sense_presence,
  output logic [2*NSLOTS-1:0]   slot_state,
  output logic [2*NSLOTS-1:0]   slot_pwr_led,
  output logic [2*NSLOTS-1:0]   slot_attn_led,
  output logic [NSLOTS-1:0]     slot_latch_open,
  output logic [2*NSLOTS-1:0]   slot_presence,
  output logic [3:0]            cmd_status,
  output logic                  cmd_detected,
  output logic [NSLOTS-1:0]     evt_button,
  output logic [NSLOTS-1:0]     evt_latch,
  output logic [NSLOTS-1:0]     evt_presence
);
  localparam int IW = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;
  localparam logic [IW-1:0] LAST = IW'(NSLOTS - 1);

  logic          busy_q, inv_q, mode_q, det_q;
  logic [IW-1:0] idx_q;
  logic [1:0]    grp_q;
  logic [NSLOTS-1:0] hit, en, lo_q, slo_q, evt_q;

  logic accept, is_slot, is_speed, is_grp, tgt_ok, rej_po, slot_ok, any_en, grp_go, bad, last;

  assign accept   = cmd_wr && !busy_q;
  assign is_slot  = cmd_code[7:6] == 2'b00;
  assign is_speed = cmd_code[7:3] == 5'b01000;
  assign is_grp   = cmd_code == 8'h48 || cmd_code == 8'h49;
  assign tgt_ok   = cmd_target != 5'd0 && int'(cmd_target) <= NSLOTS;
  assign rej_po   = cmd_code[1:0] == 2'd1 && |(hit & en);
  assign slot_ok  = accept && is_slot && tgt_ok && !rej_po;
  assign any_en   = |en;
  assign grp_go   = accept && is_grp && !any_en;
  assign bad      = (is_slot && !(tgt_ok && !rej_po)) || (is_grp && any_en) ||
                    !(is_slot || is_speed || is_grp);
  assign last     = busy_q && idx_q == LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      inv_q  <= 1'b0;
      mode_q <= 1'b0;
      det_q  <= 1'b0;
      idx_q  <= '0;
      grp_q  <= 2'd0;
    end else begin
      det_q <= (accept && !grp_go) || last;
      if (accept) begin
        inv_q  <= bad;
        mode_q <= is_speed && cmd_code[2:0] != 3'd0;
      end
      if (grp_go) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        grp_q  <= cmd_code[0] ? 2'd2 : 2'd1;
      end else if (busy_q) begin
        if (last) busy_q <= 1'b0;
        else      idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign cmd_status   = {mode_q, inv_q, 1'b0, busy_q};
  assign cmd_detected = det_q;
  assign evt_button   = evt_q;
  assign evt_latch    = evt_q;
  assign evt_presence = evt_q;

  for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
    logic [1:0] st_q, pw_q, at_q, pr_q, spr_q;
    logic [1:0] rs, rp, ra, np, na, ns;
    logic       sel, to_dis, up, empty;

    assign hit[i] = cmd_target == 5'(i + 1);
    assign en[i]  = st_q == 2'd2;
    assign sel    = (slot_ok && hit[i]) || (busy_q && idx_q == IW'(i));

    always_comb begin
      if (busy_q) begin
        rs = lo_q[i] ? 2'd0 : grp_q;
        rp = lo_q[i] ? 2'd3 : 2'd1;
        ra = 2'd0;
      end else begin
        rs = cmd_code[1:0];
        rp = cmd_code[3:2];
        ra = cmd_code[5:4];
      end
    end

    assign np     = (rp != 2'd0) ? rp : pw_q;
    assign na     = (ra != 2'd0) ? ra : at_q;
    assign to_dis = rs == 2'd3 && (st_q == 2'd1 || st_q == 2'd2);
    assign up     = st_q == 2'd3 && (rs == 2'd1 || rs == 2'd2);
    assign ns     = (to_dis || up) ? rs : st_q;
    assign empty  = sel && to_dis && np == 2'd3;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q     <= 2'd3;
        pw_q     <= 2'd3;
        at_q     <= 2'd0;
        lo_q[i]  <= 1'b1;
        pr_q     <= 2'd3;
        slo_q[i] <= 1'b1;
        spr_q    <= 2'd3;
        evt_q[i] <= 1'b0;
      end else begin
        slo_q[i] <= sense_latch_open[i];
        spr_q    <= sense_presence[2*i +: 2];
        evt_q[i] <= empty;
        if (sel) begin
          st_q <= ns;
          pw_q <= np;
          at_q <= na;
        end
        if (empty) begin
          lo_q[i] <= 1'b1;
          pr_q    <= 2'd3;
        end else begin
          if (sense_latch_open[i] != slo_q[i]) lo_q[i] <= sense_latch_open[i];
          if (sense_presence[2*i +: 2] != spr_q) pr_q <= sense_presence[2*i +: 2];
        end
      end
    end

    assign slot_state[2*i +: 2]    = st_q;
    assign slot_pwr_led[2*i +: 2]  = pw_q;
    assign slot_attn_led[2*i +: 2] = at_q;
    assign slot_presence[2*i +: 2] = pr_q;
    assign slot_latch_open[i]      = lo_q[i];

    assert_reject_po_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && is_slot && hit[i] && en[i] && cmd_code[1:0] == 2'd1)
      |=> (slot_state[2*i +: 2] == 2'd2 && $stable(slot_pwr_led[2*i +: 2])));

    assert_empty_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_button[i] |-> (slot_latch_open[i] && slot_presence[2*i +: 2] == 2'd3));
  end

  assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_slot && !tgt_ok) |=> (cmd_status[2] && $stable(slot_state)));

  assert_speed_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_speed && cmd_code[2:0] != 3'd0) |=> cmd_status[3]);

  assert_det_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_grp) |=> cmd_detected);

  assert_det_group_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_status[0]) |-> cmd_detected);

  assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_status[0] |-> !cmd_detected);

  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_status[0] && cmd_wr) |=> $stable(cmd_status[3:2]));
endmodule

// File: tb/test_hotplug_cmd_engine.sv
module test_hotplug_cmd_engine;
  localparam int CLK = 10;
  localparam int N = 3;

  logic clk = 1'b0, rst_n = 1'b0, cmd_wr = 1'b0;
  logic [7:0] cmd_code = 8'd0;
  logic [4:0] cmd_target = 5'd0;
  logic [N-1:0] s_lo = '0;
  logic [2*N-1:0] s_pr = '0;
  logic [2*N-1:0] slot_state, slot_pwr_led, slot_attn_led, slot_presence;
  logic [N-1:0] slot_latch_open, evt_button, evt_latch, evt_presence;
  logic [3:0] cmd_status;
  logic cmd_detected;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0] es[N], ep[N], ea[N], epr[N];
  logic elo[N], eev[N];
  logic [3:0] estat;
  logic edet;

  always #(CLK/2) clk = ~clk;

  hotplug_cmd_engine #(.NSLOTS(N)) i_hotplug_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .cmd_target(cmd_target), .sense_latch_open(s_lo), .sense_presence(s_pr),
    .slot_state(slot_state), .slot_pwr_led(slot_pwr_led), .slot_attn_led(slot_attn_led),
    .slot_latch_open(slot_latch_open), .slot_presence(slot_presence),
    .cmd_status(cmd_status), .cmd_detected(cmd_detected), .evt_button(evt_button),
    .evt_latch(evt_latch), .evt_presence(evt_presence));

  function automatic logic [40:0] observed();
    return {slot_state, slot_pwr_led, slot_attn_led, slot_latch_open, slot_presence,
            cmd_status, cmd_detected, evt_button, evt_latch, evt_presence};
  endfunction

  function automatic logic [40:0] expected();
    logic [2*N-1:0] s, p, a, r;
    logic [N-1:0] l, e;
    for (int i = 0; i < N; i++) begin
      s[2*i +: 2] = es[i]; p[2*i +: 2] = ep[i]; a[2*i +: 2] = ea[i];
      r[2*i +: 2] = epr[i]; l[i] = elo[i]; e[i] = eev[i];
    end
    return {s, p, a, l, r, estat, edet, e, e, e};
  endfunction

  // {state, pwr, attn, latch, presence, invalid, emptied}
  function automatic logic [10:0] model(logic [1:0] s, logic [1:0] p, logic [1:0] a,
                                        logic lo, logic [1:0] pr, logic [5:0] c);
    logic [1:0] np, na, ns;
    logic td, up, emp;
    if (c[1:0] == 2'd1 && s == 2'd2) return {s, p, a, lo, pr, 1'b1, 1'b0};
    np = (c[3:2] != 0) ? c[3:2] : p;
    na = (c[5:4] != 0) ? c[5:4] : a;
    td = c[1:0] == 2'd3 && (s == 2'd1 || s == 2'd2);
    up = s == 2'd3 && (c[1:0] == 2'd1 || c[1:0] == 2'd2);
    ns = (td || up) ? c[1:0] : s;
    emp = td && np == 2'd3;
    return {ns, np, na, emp ? 1'b1 : lo, emp ? 2'd3 : pr, 1'b0, emp};
  endfunction

  task automatic check(string tag);
    logic [40:0] act, exp;
    act = observed();
    exp = expected();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic baseline();
    for (int i = 0; i < N; i++) begin
      es[i] = 2'd3; ep[i] = 2'd3; ea[i] = 2'd0; elo[i] = s_lo[i];
      epr[i] = s_pr[2*i +: 2]; eev[i] = 1'b0;
    end
    estat = 4'd0; edet = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    baseline();
  endtask

  task automatic cmd(logic [7:0] c, logic [4:0] t);
    cmd_wr = 1'b1; cmd_code = c; cmd_target = t;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic quiet();
    edet = 1'b0;
    for (int i = 0; i < N; i++) eev[i] = 1'b0;
  endtask

  initial begin
    // R1 reset state
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < N; i++) begin
      es[i] = 2'd3; ep[i] = 2'd3; ea[i] = 2'd0; elo[i] = 1'b1; epr[i] = 2'd3; eev[i] = 1'b0;
    end
    estat = 4'd0; edet = 1'b0;
    check("R1 reset");

    // R2 R4 R5 sweep of slot codes from three starting states
    for (int st0 = 1; st0 <= 3; st0++) begin
      for (int c = 0; c < 64; c++) begin
        int t;
        logic [10:0] m;
        t = c % N;
        do_reset();
        @(negedge clk);
        if (st0 != 3) begin
          cmd(8'(st0), 5'(t + 1));
          es[t] = 2'(st0);
        end
        cmd(8'(c), 5'(t + 1));
        m = model(es[t], ep[t], ea[t], elo[t], epr[t], 6'(c));
        {es[t], ep[t], ea[t], elo[t], epr[t]} = m[10:2];
        estat = {1'b0, m[1], 2'b00};
        edet = 1'b1;
        eev[t] = m[0];
        if (m[1]) check("R4 rejected move");
        else if (m[0]) check("R5 emptying");
        else check("R2 slot command");
        @(negedge clk);
        quiet();
        check("R9 single pulse");
      end
    end

    // R3 out-of-range targets
    do_reset();
    for (int t = 0; t < 32; t++) begin
      if (t >= 1 && t <= N) continue;
      cmd(8'h3A, 5'(t));
      estat = 4'b0100; edet = 1'b1;
      check("R3 bad target");
    end

    // R6 speed codes
    do_reset();
    for (int c = 8'h40; c <= 8'h47; c++) begin
      cmd(8'(c), 5'd1);
      estat = {(c != 8'h40), 3'b000}; edet = 1'b1;
      check("R6 speed");
    end

    // R8 remaining codes and status clearing
    for (int c = 8'h4A; c <= 8'hFF; c++) begin
      cmd(8'(c), 5'd1);
      estat = 4'b0100; edet = 1'b1;
      check("R8 undefined code");
    end
    cmd(8'h41, 5'd1);
    estat = 4'b1000;
    check("R8 clear invalid");
    cmd(8'h00, 5'd1);
    estat = 4'b0000;
    check("R8 clear mode");

    // R7 R10 enable-all with a write while busy
    s_lo = 3'b010;
    do_reset();
    cmd(8'h49, 5'd1);
    estat = 4'b0001; edet = 1'b0;
    check("R10 busy start");
    cmd_wr = 1'b1; cmd_code = 8'hFF;
    @(negedge clk);
    cmd_wr = 1'b0;
    es[0] = 2'd2; ep[0] = 2'd1;
    check("R7 slot0 step");
    @(negedge clk);
    check("R7 open slot step");
    @(negedge clk);
    es[2] = 2'd2; ep[2] = 2'd1; estat = 4'b0000; edet = 1'b1;
    check("R10 ignored write, R9 end pulse");
    @(negedge clk);
    cmd(8'h48, 5'd1);
    estat = 4'b0100; edet = 1'b1;
    check("R7 refused while enabled");

    // R7 power-only all
    do_reset();
    cmd(8'h04, 5'd2);
    ep[1] = 2'd1; edet = 1'b1;
    check("R2 power led write");
    cmd(8'h48, 5'd1);
    edet = 1'b0; estat = 4'b0001;
    @(negedge clk); @(negedge clk); @(negedge clk);
    es[0] = 2'd1; ep[0] = 2'd1; ep[1] = 2'd3; es[2] = 2'd1; ep[2] = 2'd1;
    estat = 4'b0000; edet = 1'b1;
    check("R7 power-only all");

    // R11 sense inputs
    s_lo = 3'b000;
    do_reset();
    s_lo[2] = 1'b1; s_pr[5:4] = 2'd1;
    @(negedge clk);
    elo[2] = 1'b1; epr[2] = 2'd1;
    check("R11 sense follow");
    s_lo = 3'b000; s_pr = '0;
    do_reset();
    cmd(8'h02, 5'd1);
    es[0] = 2'd2; edet = 1'b1;
    s_pr[1:0] = 2'd2;
    cmd(8'h0F, 5'd1);
    es[0] = 2'd3; ep[0] = 2'd3; elo[0] = 1'b1; epr[0] = 2'd3; eev[0] = 1'b1;
    check("R11 emptying wins");
    @(negedge clk);
    quiet();
    check("R11 emptied held");
    s_pr[1:0] = 2'd1;
    @(negedge clk);
    epr[0] = 2'd1;
    check("R11 later sense change");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule